// File: doc/BRIEF.md
# Programmable Chip-Select Unit

This block turns processor bus cycles into chip-select strobes for external memories and peripherals. It has a set of general channels plus one boot channel. Each channel has three registers. A pin-function field says whether the pin acts as a chip-select and how wide its port is. A base register holds the block start address and the block size. An option register selects which cycles the channel answers: byte lanes, direction, address space, interrupt level, strobe timing, wait states and autovector. The unit compares every bus cycle against all channels in parallel. It raises the select of each channel that matches. It also produces an internal termination pulse after the programmed number of wait states.

The pin functions come from the data bus while reset is held. They are captured on the first clock after reset is released, and the boot port width comes from the lowest data line. The boot channel leaves reset ready to serve the vector fetches. Every general channel stays silent until software gives it a byte-lane setting other than disabled. For interrupt-acknowledge cycles a channel can answer on its own with an internal autovector termination.

Top module: `csu_top`

## Requirements
- R1: On the first clock after reset release, the 2-bit pin field of general channel i becomes {data_in[i+1], 1}. The boot channel field becomes {1, data_in[0]}. Pin field encoding: 00 discrete, 01 alternate function, 10 chip-select with an 8-bit port, 11 chip-select with a 16-bit port. pin_cfg[2i+1:2i] shows channel i, and the boot channel is index NCH.
- R2: Reset sets every general option register to zero, so its byte-lane field is disabled. A general channel with lanes = 00 never asserts its select.
- R3: Out of reset the boot channel has base 0, block size 2 KB, both lanes, read and write, user or supervisor space and 13 wait states. It matches any such cycle below address 0x800.
- R4: Base register layout: bits [15:3] hold address bits [23:11], and bits [2:0] hold size n, giving a block of 2 KB << n. Address bits below 11+n are ignored in the compare, both in the cycle address and in the base.
- R5: Option bits [15:14] select byte lanes: 00 never, 01 lower strobe (lb), 10 upper strobe (ub), 11 either.
- R6: Option bits [13:12] select direction: bit 12 allows reads and bit 13 allows writes. Option bits [6:5] select space: 00 CPU space, 01 user, 10 supervisor, 11 user or supervisor. The cycle's spc input uses 0 CPU, 1 user, 2 supervisor, and 3 is reserved and matches nothing.
- R7: A channel asserts its select only while its pin field has bit 1 set (chip-select function).
- R8: Option bit 11 picks the qualifying strobe: 0 for as_valid, 1 for ds_valid. A select rises one clock after the qualifying strobe is first sampled together with a match. It falls one clock after the strobe drops.
- R9: Option bits [10:7] hold the wait count w. For w from 0 to 13, term pulses for one cycle w clocks after as_valid is first sampled. For w of 14 or 15 there is no internal termination.
- R10: A CPU-space channel matches only iack cycles in CPU space, and it ignores the address. Level field bits [4:2] equal to 0 accept any level; otherwise the field must equal lvl. The lane comes from the port width: a 16-bit port needs lane bit 14 (lower) and an 8-bit port needs lane bit 15 (upper). With option bit 1 set, avec pulses together with term.
- R11: Writes use wr_kind 0 for base, 1 for option and 2 for pin field. A write replaces the captured pin field, and the captured value holds until then or until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | $clog2(NCH+1) | Channel index; NCH is the boot channel |
| wr_kind | input | 2 | Register select: 0 base, 1 option, 2 pin field |
| data_in | input | 16 | Write data; also sampled at reset release |
| as_valid | input | 1 | Address strobe of the current cycle |
| ds_valid | input | 1 | Data strobe of the current cycle |
| addr | input | 24 | Cycle address |
| rd | input | 1 | 1 for read, 0 for write |
| spc | input | 2 | Address space of the cycle |
| ub | input | 1 | Upper byte lane active |
| lb | input | 1 | Lower byte lane active |
| iack | input | 1 | Interrupt-acknowledge cycle |
| lvl | input | 3 | Interrupt level being acknowledged |
| cs | output | NCH+1 | Registered select per channel |
| pin_cfg | output | 2*(NCH+1) | Current pin field of every channel |
| term | output | 1 | Internal cycle termination pulse |
| avec | output | 1 | Internal autovector pulse |

## Verification
The assertions assume as_valid and the cycle attributes stay steady while a cycle is in progress. They also assume ds_valid rises only while as_valid is held, and data_in stays steady across the release of reset. The bench holds each cycle for sixteen clocks and changes address, direction, space and lanes only while both strobes are low. It raises ds_valid only inside an address-strobe window, writes registers only between cycles, and keeps data_in fixed from reset entry until the capture clock has passed.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int AW = 24;
  localparam int LSB = 11;
  localparam int BW = AW - LSB;

  typedef enum logic [1:0] {
    KIND_BASE = 2'd0,
    KIND_OPT  = 2'd1,
    KIND_PIN  = 2'd2
  } csu_kind_e;

  typedef struct packed {
    logic [BW-1:0] base;
    logic [2:0]    size;
  } csu_base_t;

  typedef struct packed {
    logic [1:0] lanes;
    logic [1:0] dir;
    logic       strb_ds;
    logic [3:0] wait_n;
    logic [1:0] spc;
    logic [2:0] lvl;
    logic       avec;
    logic       rsvd;
  } csu_opt_t;

  localparam csu_opt_t BOOT_OPT_RST = '{
    lanes: 2'b11, dir: 2'b11, strb_ds: 1'b0, wait_n: 4'd13,
    spc: 2'b11, lvl: 3'd0, avec: 1'b0, rsvd: 1'b0};
endpackage

// File: rtl/csu_regs.sv
module csu_regs
  import csu_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SELW = $clog2(NCH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SELW-1:0]         wr_sel,
  input  logic [1:0]              wr_kind,
  input  logic [15:0]             data_in,
  output csu_base_t [NCH:0]       base_o,
  output csu_opt_t  [NCH:0]       opt_o,
  output logic      [NCH:0][1:0]  pin_o
);
  csu_base_t [NCH:0]      base_q, base_d;
  csu_opt_t  [NCH:0]      opt_q, opt_d;
  logic      [NCH:0][1:0] pin_q, pin_d;
  logic                   cap_q, cap_d;
  logic                   upd;

  always_comb begin
    base_d = base_q;
    opt_d  = opt_q;
    pin_d  = pin_q;
    cap_d  = cap_q;
    upd    = !cap_q || wr_en;
    if (!cap_q) begin
      cap_d = 1'b1;
      for (int i = 0; i < NCH; i++) pin_d[i] = {data_in[i+1], 1'b1};
      pin_d[NCH] = {1'b1, data_in[0]};
    end else if (wr_en && (32'(wr_sel) <= NCH)) begin
      case (wr_kind)
        KIND_BASE: base_d[wr_sel] = data_in;
        KIND_OPT:  opt_d[wr_sel]  = data_in;
        KIND_PIN:  pin_d[wr_sel]  = data_in[1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      opt_q      <= '0;
      opt_q[NCH] <= BOOT_OPT_RST;
      pin_q      <= '1;
      cap_q      <= 1'b0;
    end else if (upd) begin
      base_q <= base_d;
      opt_q  <= opt_d;
      pin_q  <= pin_d;
      cap_q  <= cap_d;
    end
  end

  assign base_o = base_q;
  assign opt_o  = opt_q;
  assign pin_o  = pin_q;

  // R1
  boot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_q) |-> pin_q[NCH] == {1'b1, $past(data_in[0])});

  // R11
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_q) && !$past(wr_en)) |-> $stable(pin_q));
endmodule

// File: rtl/csu_match.sv
module csu_match
  import csu_pkg::*;
(
  input  csu_base_t       base,
  input  csu_opt_t        opt,
  input  logic [1:0]      pin,
  input  logic [AW-1:0]   addr,
  input  logic            rd,
  input  logic [1:0]      spc,
  input  logic            ub,
  input  logic            lb,
  input  logic            iack,
  input  logic [2:0]      lvl,
  output logic            hit,
  output logic            cpu
);
  logic [AW-1:0] keep;
  logic addr_ok, dir_ok, lvl_ok, cpu_lane, mem_lane, spc_ok, mem;

  always_comb begin
    keep     = {AW{1'b1}} << (5'(LSB) + 5'(base.size));
    addr_ok  = ((addr ^ {base.base, {LSB{1'b0}}}) & keep) == '0;
    dir_ok   = rd ? opt.dir[0] : opt.dir[1];
    lvl_ok   = (opt.lvl == 3'd0) || (opt.lvl == lvl);
    cpu_lane = pin[0] ? opt.lanes[0] : opt.lanes[1];
    mem_lane = (opt.lanes[0] && lb) || (opt.lanes[1] && ub);
    case (opt.spc)
      2'b01:   spc_ok = (spc == 2'd1);
      2'b10:   spc_ok = (spc == 2'd2);
      2'b11:   spc_ok = (spc == 2'd1) || (spc == 2'd2);
      default: spc_ok = 1'b0;
    endcase
    cpu = (opt.spc == 2'b00) && (spc == 2'd0) && iack && lvl_ok && cpu_lane;
    mem = spc_ok && addr_ok && mem_lane;
    hit = pin[1] && dir_ok && (cpu || mem);
  end
endmodule

// File: rtl/csu_top.sv
module csu_top
  import csu_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SELW = $clog2(NCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SELW-1:0]       wr_sel,
  input  logic [1:0]            wr_kind,
  input  logic [15:0]           data_in,
  input  logic                  as_valid,
  input  logic                  ds_valid,
  input  logic [23:0]           addr,
  input  logic                  rd,
  input  logic [1:0]            spc,
  input  logic                  ub,
  input  logic                  lb,
  input  logic                  iack,
  input  logic [2:0]            lvl,
  output logic [NCH:0]          cs,
  output logic [2*NCH+1:0]      pin_cfg,
  output logic                  term,
  output logic                  avec
);
  localparam logic [3:0] WMAX = 4'd13;

  csu_base_t [NCH:0]      base;
  csu_opt_t  [NCH:0]      opt;
  logic      [NCH:0][1:0] pin;
  logic      [NCH:0]      hit, cpu, qual, fire;
  logic      [NCH:0]      cs_q, cs_d;
  logic      [3:0]        cnt_q, cnt_d;
  logic                   term_q, term_d, avec_q, avec_d;

  csu_regs #(.NCH(NCH), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_kind(wr_kind), .data_in(data_in),
    .base_o(base), .opt_o(opt), .pin_o(pin));

  for (genvar g = 0; g <= NCH; g++) begin : g_ch
    csu_match u_match (
      .base(base[g]), .opt(opt[g]), .pin(pin[g]), .addr(addr), .rd(rd),
      .spc(spc), .ub(ub), .lb(lb), .iack(iack), .lvl(lvl),
      .hit(hit[g]), .cpu(cpu[g]));
    assign qual[g] = hit[g] && (opt[g].strb_ds ? ds_valid : as_valid);
    assign fire[g] = qual[g] && as_valid && (opt[g].wait_n <= WMAX)
                     && (opt[g].wait_n == cnt_q);
    assign pin_cfg[2*g+1:2*g] = pin[g];

    // R2
    disabled_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q[g] |-> $past(opt[g].lanes != 2'b00 && pin[g][1]));

    // R8
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q[g] |-> $past(as_valid || ds_valid));
  end

  always_comb begin
    cnt_d  = !as_valid ? 4'd0 : ((cnt_q == 4'd15) ? cnt_q : cnt_q + 4'd1);
    cs_d   = qual;
    term_d = |fire;
    avec_d = 1'b0;
    for (int i = 0; i <= NCH; i++)
      if (fire[i] && cpu[i] && opt[i].avec) avec_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cs_q   <= '0;
      term_q <= 1'b0;
      avec_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cs_q   <= cs_d;
      term_q <= term_d;
      avec_q <= avec_d;
    end
  end

  assign cs   = cs_q;
  assign term = term_q;
  assign avec = avec_q;

  // R9
  term_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> (cs_q != '0));

  // R9
  term_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |=> (!term_q || !$past(as_valid) || !as_valid));

  // R10
  avec_with_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avec_q |-> term_q);
endmodule

// File: tb/test_csu_top.sv
`timescale 1ns/1ps
module test_csu_top;
  localparam int NCH  = 4;
  localparam int SELW = $clog2(NCH + 1);
  localparam logic [NCH:0] BOOT = (NCH+1)'(1) << NCH;

  logic clk = 1'b0;
  logic rst_n, wr_en, as_valid, ds_valid, rd, ub, lb, iack;
  logic [SELW-1:0] wr_sel;
  logic [1:0] wr_kind, spc;
  logic [15:0] data_in;
  logic [23:0] addr;
  logic [2:0] lvl;
  logic [NCH:0] cs;
  logic [2*NCH+1:0] pin_cfg;
  logic term, avec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csu_top #(.NCH(NCH)) i_csu_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_kind(wr_kind), .data_in(data_in), .as_valid(as_valid),
    .ds_valid(ds_valid), .addr(addr), .rd(rd), .spc(spc), .ub(ub),
    .lb(lb), .iack(iack), .lvl(lvl), .cs(cs), .pin_cfg(pin_cfg),
    .term(term), .avec(avec));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] d);
    @(negedge clk);
    rst_n = 1'b0; data_in = d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [1:0] kind, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SELW'(sel); wr_kind = kind; data_in = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] optw(input logic [1:0] ln, input logic [1:0] dr,
      input logic sd, input logic [3:0] w, input logic [1:0] sp,
      input logic [2:0] lv, input logic av);
    return {ln, dr, sd, w, sp, lv, av, 1'b0};
  endfunction

  function automatic logic [15:0] basew(input logic [23:0] a, input logic [2:0] n);
    return {a[23:11], n};
  endfunction

  logic [NCH:0] got_cs, cs_after;
  int cs_at, term_at;
  logic av_seen;

  task automatic bus(input logic [23:0] a, input logic r, input logic [1:0] s,
      input logic u, input logic l, input logic ia, input logic [2:0] lv, input int d);
    @(negedge clk);
    addr = a; rd = r; spc = s; ub = u; lb = l; iack = ia; lvl = lv;
    as_valid = 1'b1; ds_valid = (d == 0);
    got_cs = '0; cs_at = -1; term_at = -1; av_seen = 1'b0;
    for (int c = 0; c < 16; c++) begin
      @(posedge clk); @(negedge clk);
      if (cs != '0 && cs_at < 0) begin cs_at = c; got_cs = cs; end
      if (term && term_at < 0) term_at = c;
      if (avec) av_seen = 1'b1;
      if (c + 1 == d) ds_valid = 1'b1;
    end
    as_valid = 1'b0; ds_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    cs_after = cs;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*NCH+1:0] exp_pin;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_kind = '0; data_in = '0;
    as_valid = 1'b0; ds_valid = 1'b0; addr = '0; rd = 1'b1; spc = 2'd2;
    ub = 1'b1; lb = 1'b1; iack = 1'b0; lvl = '0;

    // R1 with data0 low: generals alternate function, boot 8-bit chip-select
    do_reset(16'h0000);
    exp_pin = '0;
    for (int i = 0; i < NCH; i++) exp_pin[2*i +: 2] = 2'b01;
    exp_pin[2*NCH +: 2] = 2'b10;
    chk("R1 pins data0 low", 64'(pin_cfg), 64'(exp_pin));

    // R3 boot serves a supervisor read and a user write
    bus(24'h000100, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R3 boot select", 64'(got_cs), 64'(BOOT));
    chk("R3 boot wait 13", 64'(term_at), 64'(13));
    bus(24'h0007FE, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 3'd0, 0);
    chk("R3 boot user write", 64'(got_cs), 64'(BOOT));
    bus(24'h000800, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R3 boot outside 2K", 64'(got_cs), 64'(0));
    chk("R3 boot outside no term", 64'(term_at), 64'hFFFF_FFFF_FFFF_FFFF);

    // R2 general channels silent after reset
    bus(24'h000000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1, 0);
    chk("R2 reset iack silent", 64'(got_cs), 64'(0));

    // R7 alternate-function pin blocks its select
    wr(0, 2'd0, basew(24'h100000, 3'd0));
    wr(0, 2'd1, optw(2'b11, 2'b11, 1'b0, 4'd2, 2'b11, 3'd0, 1'b0));
    bus(24'h100000, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R7 alt pin no select", 64'(got_cs), 64'(0));

    // R11 software write overrides captured pin field
    wr(0, 2'd2, 16'h0003);
    chk("R11 pin write seen", 64'(pin_cfg[1:0]), 64'(2'b11));
    bus(24'h100000, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R11 select after write", 64'(got_cs), 64'(1));
    chk("R9 wait 2", 64'(term_at), 64'(2));

    // R1 with data lines high
    do_reset(16'h001F);
    for (int i = 0; i <= NCH; i++) exp_pin[2*i +: 2] = 2'b11;
    chk("R1 pins data high", 64'(pin_cfg), 64'(exp_pin));
    bus(24'h100000, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R2 reset clears options", 64'(got_cs), 64'(0));

    // R4 block size sweep
    wr(0, 2'd1, optw(2'b11, 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
    for (int n = 0; n < 8; n++) begin
      logic [23:0] sz;
      sz = 24'(2048) << n;
      wr(0, 2'd0, basew(24'h100000, 3'(n)));
      bus(24'h100000 + sz - 24'd1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
      chk($sformatf("R4 top of block n=%0d", n), 64'(got_cs), 64'(1));
      bus(24'h100000 + sz, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
      chk($sformatf("R4 past block n=%0d", n), 64'(got_cs), 64'(0));
      bus(24'h0FFFFF, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
      chk($sformatf("R4 below block n=%0d", n), 64'(got_cs), 64'(0));
    end
    wr(0, 2'd0, basew(24'h100800, 3'd1));
    bus(24'h100000, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
    chk("R4 base low bits masked", 64'(got_cs), 64'(1));
    wr(0, 2'd0, basew(24'h100000, 3'd0));

    // R5 byte-lane sweep
    for (int ln = 0; ln < 4; ln++)
      for (int p = 1; p < 4; p++) begin
        logic u, l, e;
        u = p[1]; l = p[0];
        e = (ln[0] && l) || (ln[1] && u);
        wr(0, 2'd1, optw(2'(ln), 2'b11, 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
        bus(24'h100010, 1'b1, 2'd2, u, l, 1'b0, 3'd0, 0);
        chk($sformatf("R5 lanes=%0d ub=%0d lb=%0d", ln, u, l), 64'(got_cs), 64'(e));
      end

    // R6 direction sweep
    for (int dr = 0; dr < 4; dr++)
      for (int r = 0; r < 2; r++) begin
        logic e;
        e = (r == 1) ? dr[0] : dr[1];
        wr(0, 2'd1, optw(2'b11, 2'(dr), 1'b0, 4'd0, 2'b11, 3'd0, 1'b0));
        bus(24'h100020, 1'(r), 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
        chk($sformatf("R6 dir=%0d rd=%0d", dr, r), 64'(got_cs), 64'(e));
      end

    // R6 space sweep
    for (int so = 1; so < 4; so++)
      for (int sc = 1; sc < 4; sc++) begin
        logic e;
        e = (sc != 3) && ((so == 3) || (so == sc));
        wr(0, 2'd1, optw(2'b11, 2'b11, 1'b0, 4'd0, 2'(so), 3'd0, 1'b0));
        bus(24'h100030, 1'b1, 2'(sc), 1'b1, 1'b1, 1'b0, 3'd0, 0);
        chk($sformatf("R6 optspc=%0d cycspc=%0d", so, sc), 64'(got_cs), 64'(e));
      end

    // R9 wait sweep, R8 fall after strobe drop
    for (int w = 0; w < 16; w++) begin
      wr(0, 2'd1, optw(2'b11, 2'b11, 1'b0, 4'(w), 2'b11, 3'd0, 1'b0));
      bus(24'h100040, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 0);
      chk($sformatf("R8 select rise w=%0d", w), 64'(cs_at), 64'(0));
      chk($sformatf("R9 term w=%0d", w), 64'(term_at),
          (w < 14) ? 64'(w) : 64'hFFFF_FFFF_FFFF_FFFF);
      chk($sformatf("R8 select fall w=%0d", w), 64'(cs_after), 64'(0));
    end

    // R8 data-strobe qualification
    wr(0, 2'd1, optw(2'b11, 2'b11, 1'b1, 4'd6, 2'b11, 3'd0, 1'b0));
    bus(24'h100050, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 3);
    chk("R8 ds strobe rise", 64'(cs_at), 64'(3));
    chk("R8 ds strobe term", 64'(term_at), 64'(6));
    wr(0, 2'd1, optw(2'b11, 2'b11, 1'b0, 4'd6, 2'b11, 3'd0, 1'b0));
    bus(24'h100050, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 3);
    chk("R8 as strobe rise", 64'(cs_at), 64'(0));

    // R10 interrupt acknowledge on channel 1 (16-bit port)
    wr(1, 2'd1, optw(2'b01, 2'b01, 1'b0, 4'd1, 2'b00, 3'd3, 1'b1));
    bus(24'hABCDEF, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd3, 0);
    chk("R10 iack level match", 64'(got_cs), 64'(2));
    chk("R10 iack term", 64'(term_at), 64'(1));
    chk("R10 autovector", 64'(av_seen), 64'(1));
    bus(24'hABCDEF, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd2, 0);
    chk("R10 level mismatch", 64'(got_cs), 64'(0));
    chk("R10 no avec on miss", 64'(av_seen), 64'(0));
    bus(24'hABCDEF, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, 0);
    chk("R10 needs iack", 64'(got_cs), 64'(0));
    wr(1, 2'd1, optw(2'b01, 2'b01, 1'b0, 4'd1, 2'b00, 3'd0, 1'b0));
    bus(24'h000123, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5, 0);
    chk("R10 any level", 64'(got_cs), 64'(2));
    chk("R10 avec off", 64'(av_seen), 64'(0));
    wr(1, 2'd1, optw(2'b10, 2'b01, 1'b0, 4'd1, 2'b00, 3'd0, 1'b1));
    bus(24'h000123, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5, 0);
    chk("R10 upper lane on 16-bit port", 64'(got_cs), 64'(0));
    wr(1, 2'd2, 16'h0002);
    bus(24'h000123, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5, 0);
    chk("R10 upper lane on 8-bit port", 64'(got_cs), 64'(2));
    chk("R10 avec 8-bit", 64'(av_seen), 64'(1));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule